// File: doc/BRIEF.md
# MDIO Management Frame Master

This block runs register accesses to Ethernet PHYs over the two-wire management bus. A host requests an access with a one-cycle start strobe. With the strobe it gives a read/write select, a 5-bit PHY address, a 5-bit register address and, for writes, a 16-bit value. The block then produces the management clock on `mdc` and drives or releases the data line through a split output/enable/input interface. An external pad cell combines these into the bidirectional pin.

Every access opens with a preamble of 32 clocks. The header follows: the start pattern, the opcode and both addresses. A write then sends the turnaround and the data word. A read releases the line and checks that the PHY pulls the first turnaround bit low. If the line stays high, no PHY answered. The block then clocks 32 recovery cycles with the line released and reports an error. Otherwise it shifts in the 16-bit register value. The `half_div` input sets the length of each MDC phase in system clocks. Each frame ends with an idle MDC cycle in which the line is released. `done` then pulses for one cycle.

Top module: `mdio_master`

## Requirements
- R1: Each frame begins with 32 MDC cycles during which `mdio_oe`=1 and `mdio_out`=1.
- R2: After the preamble the block drives the start bits 0,1 and then the opcode: 1,0 for a read (`rd_req`=1) and 0,1 for a write (`rd_req`=0).
- R3: After the opcode, the 5-bit PHY address and then the 5-bit register address are driven, each most significant bit first.
- R4: `mdio_out` and `mdio_oe` change only while `mdc` is low. Every MDC cycle is one low phase followed by one high phase of equal length.
- R5: On a read, `mdio_oe` is 0 from MDC cycle 46 (0-based, the first turnaround cycle) to the end of the frame. `mdio_in` is sampled at the end of that cycle's high phase.
- R6: If the sampled turnaround bit is 1, the block runs 32 more MDC cycles with the line released. It then finishes with `err`=1 and `rd_data`=0, for a frame of 79 MDC cycles.
- R7: On a successful read, 16 bits are sampled at the end of the high phases of MDC cycles 47 to 62, most significant bit first, and appear on `rd_data`.
- R8: A successful read is 64 MDC cycles long. It ends with one idle cycle with the line released, and `mdc` stays high until the cycle in which `done` pulses.
- R9: On a write, MDC cycles 46 and 47 drive the turnaround 1,0. Cycles 48 to 63 carry `wr_data` MSB first. One more released idle cycle follows, for a frame of 65 MDC cycles.
- R10: Each MDC phase lasts `half_div` system clocks, and a value of 0 acts as 1. `busy` stays high for exactly 2·H·(frame MDC cycles) clocks.
- R11: While no frame is active, `mdc`=0 and `mdio_oe`=0. After reset `busy`, `done` and `err` are 0 and `rd_data` is 0.
- R12: `start` is ignored while `busy`=1. `done` is a one-cycle pulse in the cycle `busy` falls. `rd_data` and `err` hold until the next accepted start, and that start clears `err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request strobe, taken only while idle |
| rd_req | input | 1 | 1 = read access, 0 = write access |
| phy_addr | input | 5 | Target PHY address |
| reg_addr | input | 5 | Target register address |
| wr_data | input | 16 | Value to write |
| half_div | input | DIV_W | MDC phase length in system clocks (0 acts as 1) |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Data value toward the pad |
| mdio_oe | output | 1 | Pad drive enable |
| mdio_in | input | 1 | Data value read from the pad |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle end-of-frame pulse |
| rd_data | output | 16 | Captured register value |
| err | output | 1 | No PHY answered the last read |

## Verification
Assertions check on every cycle the behaviour that is local in time. They check that the data line and its enable stay put while MDC is high, and that MDC is low and the pad released whenever no frame runs. They also check that `done` is a single pulse at the fall of `busy`, that results hold between frames, and that the phase counter never overruns its limit. Other behaviour can only be shown by the bench's scenarios. That covers the bit order of preamble, header, turnaround and data, the exact cycle counts of the three frame shapes, the released window on reads and the recovery run after a missing PHY. The bench's scenarios also show that a start strobe arriving mid-frame leaves the frame unchanged.

// File: rtl/mdio_pkg.sv
// Shared constants, state encoding and frame-word builder for the MDIO master.
// Assumes clause-22 framing: 32-cycle preamble, 14 header bits, 2 turnaround
// bits and 16 data bits.
package mdio_pkg;

    localparam int ADDR_W      = 5;
    localparam int DATA_W      = 16;
    localparam int FRAME_W     = 4 + 2 * ADDR_W + 2 + DATA_W;   // 32 driven bits on a write
    localparam int HDR_BITS    = 4 + 2 * ADDR_W;                // 14 driven bits on a read
    localparam int PRE_CELLS   = 32;
    localparam int RECOV_CELLS = 32;
    localparam int CNT_W       = 6;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_SEND  = 3'd2,
        ST_RTA   = 3'd3,
        ST_RDATA = 3'd4,
        ST_RECOV = 3'd5,
        ST_TAIL  = 3'd6
    } mdio_state_e;

    // Assemble the serial word sent after the preamble, MSB first.
    function automatic logic [FRAME_W-1:0] frame_word(
        input logic              rd,
        input logic [ADDR_W-1:0] phy,
        input logic [ADDR_W-1:0] rg,
        input logic [DATA_W-1:0] wd
    );
        logic [1:0] op;
        op = rd ? 2'b10 : 2'b01;
        return {2'b01, op, phy, rg, 2'b10, wd};
    endfunction

endpackage

// File: rtl/mdio_phase_gen.sv
// MDC phase timer: while run is high, pulses tick once every H system clocks,
// where H = half_div, with 0 treated as 1. Assumes half_div is held constant
// for the length of a frame.
module mdio_phase_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim;

    // Effective phase length, never below one clock.
    always_comb lim = (half_div == '0) ? {{(DIV_W-1){1'b0}}, 1'b1} : half_div;

    assign tick = run && (cnt_q >= lim - 1'b1);

    // Count system clocks inside the current phase.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (!run || tick)   cnt_q <= '0;
        else                     cnt_q <= cnt_q + 1'b1;
    end

    AST_PHASE_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $stable(half_div)) |-> (cnt_q < lim)); // R10

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && half_div > 1 && $stable(half_div)) |=> !tick); // R10

endmodule

// File: rtl/mdio_tx_shift.sv
// Serialiser for the driven part of a frame: loads the whole word at the
// start of a frame and moves it up one bit per MDC cycle. The current bit is
// the MSB.
module mdio_tx_shift #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_word,
    input  logic         shift,
    output logic         msb
);

    logic [W-1:0] sr_q;

    assign msb = sr_q[W-1];

    // Load on frame start, otherwise advance one bit per shift request.
    always_ff @(posedge clk) begin
        if (!rst_n)     sr_q <= '0;
        else if (load)  sr_q <= load_word;
        else if (shift) sr_q <= {sr_q[W-2:0], 1'b0};
    end

endmodule

// File: rtl/mdio_rx_shift.sv
// Deserialiser for read data: cleared at frame start, shifts one sampled bit
// in at the LSB per request, so the first bit received ends as the MSB.
module mdio_rx_shift #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         shift,
    input  logic         din,
    output logic [W-1:0] data
);

    // Clear on accepted start, accumulate during the read data window.
    always_ff @(posedge clk) begin
        if (!rst_n)     data <= '0;
        else if (clear) data <= '0;
        else if (shift) data <= {data[W-2:0], din};
    end

endmodule

// File: rtl/mdio_frame_ctrl.sv
// Frame sequencer: owns MDC, walks preamble, header, turnaround, data and
// tail segments one MDC cycle at a time, and decides when the pad is driven.
// Assumes tick arrives only while run is high; each tick ends one MDC phase.
module mdio_frame_ctrl
    import mdio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic rd_req,
    input  logic tick,
    input  logic tx_msb,
    input  logic mdio_in,
    output logic run,
    output logic busy,
    output logic done,
    output logic err,
    output logic mdc,
    output logic mdio_out,
    output logic mdio_oe,
    output logic tx_load,
    output logic tx_shift,
    output logic rx_clear,
    output logic rx_shift
);

    localparam logic [CNT_W-1:0] PRE_LAST   = CNT_W'(PRE_CELLS - 1);
    localparam logic [CNT_W-1:0] RDHDR_LAST = CNT_W'(HDR_BITS - 1);
    localparam logic [CNT_W-1:0] WR_LAST    = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] RECOV_LAST = CNT_W'(RECOV_CELLS - 1);

    mdio_state_e      state_q;
    logic [CNT_W-1:0] cnt_q;
    logic             rd_q;
    logic             mdc_q;
    logic             err_q;
    logic             done_q;
    logic             accept;
    logic             cell_end;
    logic [CNT_W-1:0] send_last;

    assign accept    = start && (state_q == ST_IDLE);
    assign cell_end  = tick && mdc_q;
    assign send_last = rd_q ? RDHDR_LAST : WR_LAST;

    assign run      = (state_q != ST_IDLE);
    assign busy     = run;
    assign done     = done_q;
    assign err      = err_q;
    assign mdc      = mdc_q;
    assign tx_load  = accept;
    assign rx_clear = accept;
    assign tx_shift = cell_end && (state_q == ST_SEND);
    assign rx_shift = cell_end && (state_q == ST_RDATA);

    // Pad drive: preamble ones, then the serial word, otherwise released.
    always_comb begin
        mdio_oe  = 1'b0;
        mdio_out = 1'b0;
        if (state_q == ST_PRE) begin
            mdio_oe  = 1'b1;
            mdio_out = 1'b1;
        end else if (state_q == ST_SEND) begin
            mdio_oe  = 1'b1;
            mdio_out = tx_msb;
        end
    end

    // Sequence state, MDC level, segment counter and result flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            rd_q    <= 1'b0;
            mdc_q   <= 1'b0;
            err_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (state_q == ST_IDLE) begin
                mdc_q <= 1'b0;
                if (accept) begin
                    state_q <= ST_PRE;
                    cnt_q   <= '0;
                    rd_q    <= rd_req;
                    err_q   <= 1'b0;
                end
            end else if (tick) begin
                mdc_q <= ~mdc_q;
                if (mdc_q) begin
                    unique case (state_q)
                        ST_PRE: begin
                            if (cnt_q == PRE_LAST) begin
                                state_q <= ST_SEND;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        ST_SEND: begin
                            if (cnt_q == send_last) begin
                                state_q <= rd_q ? ST_RTA : ST_TAIL;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        ST_RTA: begin
                            cnt_q <= '0;
                            if (mdio_in) begin
                                err_q   <= 1'b1;
                                state_q <= ST_RECOV;
                            end else begin
                                state_q <= ST_RDATA;
                            end
                        end
                        ST_RDATA: begin
                            if (cnt_q == DATA_LAST) begin
                                state_q <= ST_TAIL;
                                cnt_q   <= '0;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        ST_RECOV: begin
                            if (cnt_q == RECOV_LAST) begin
                                state_q <= ST_IDLE;
                                cnt_q   <= '0;
                                done_q  <= 1'b1;
                            end else begin
                                cnt_q <= cnt_q + 1'b1;
                            end
                        end
                        ST_TAIL: begin
                            state_q <= ST_IDLE;
                            cnt_q   <= '0;
                            done_q  <= 1'b1;
                        end
                        default: state_q <= ST_IDLE;
                    endcase
                end
            end
        end
    end

    AST_PAD_HOLD_WHILE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mdc_q && $past(mdc_q)) |-> ($stable(mdio_out) && $stable(mdio_oe))); // R4

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc_q && !mdio_oe)); // R11

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q); // R12

    AST_DONE_AT_BUSY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (!busy && $past(busy))); // R12

    AST_ERR_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> rd_q); // R6

    AST_ERR_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(err_q)); // R12

endmodule

// File: rtl/mdio_master.sv
// MDIO management frame master top: ties the phase timer, the serialiser,
// the read deserialiser and the frame sequencer together. Assumes an external
// pad merges mdio_out/mdio_oe/mdio_in, and that half_div stays constant
// during a frame.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              rd_req,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [DIV_W-1:0]  half_div,
    output logic              mdc,
    output logic              mdio_out,
    output logic              mdio_oe,
    input  logic              mdio_in,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              err
);

    logic               run;
    logic               tick;
    logic               tx_load;
    logic               tx_shift;
    logic               tx_msb;
    logic               rx_clear;
    logic               rx_shift;
    logic [FRAME_W-1:0] word;

    // Serial word captured at the accepted start.
    always_comb word = frame_word(rd_req, phy_addr, reg_addr, wr_data);

    mdio_phase_gen #(.DIV_W(DIV_W)) u_phase (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .half_div (half_div),
        .tick     (tick)
    );

    mdio_tx_shift #(.W(FRAME_W)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (tx_load),
        .load_word (word),
        .shift     (tx_shift),
        .msb       (tx_msb)
    );

    mdio_rx_shift #(.W(DATA_W)) u_rx (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (rx_clear),
        .shift (rx_shift),
        .din   (mdio_in),
        .data  (rd_data)
    );

    mdio_frame_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_req   (rd_req),
        .tick     (tick),
        .tx_msb   (tx_msb),
        .mdio_in  (mdio_in),
        .run      (run),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .tx_load  (tx_load),
        .tx_shift (tx_shift),
        .rx_clear (rx_clear),
        .rx_shift (rx_shift)
    );

    AST_RDDATA_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> $stable(rd_data)); // R12

    AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!mdio_oe && !mdc)); // R8

endmodule

// File: tb/sim_mdio_master.sv
// Directed bench for mdio_master with a behavioural PHY on the management bus.
module sim_mdio_master;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_req = 1'b0;
    logic [4:0]  phy_addr = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  half_div = 8'd1;
    logic        mdc;
    logic        mdio_out;
    logic        mdio_oe;
    logic        mdio_in = 1'b1;
    logic        busy;
    logic        done;
    logic [15:0] rd_data;
    logic        err;

    int total = 0;
    int bad = 0;

    // PHY model settings, written by the scenario tasks only
    logic        phy_present = 1'b1;
    logic [15:0] phy_word = '0;
    int          exp_h = 1;

    // Monitor state, written by the monitor only
    int          rise_k = 0;
    logic [79:0] drv_v = '0;
    logic [79:0] oe_v = '0;
    int          clk_n = 0;
    int          last_rise = 0;
    int          spacing_bad = 0;
    int          hi_change_bad = 0;
    logic        prev_mdc = 1'b0;
    logic        prev_out = 1'b0;
    logic        prev_oe = 1'b0;
    logic        prev_busy = 1'b0;

    always #5 clk = ~clk;

    mdio_master u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .rd_req   (rd_req),
        .phy_addr (phy_addr),
        .reg_addr (reg_addr),
        .wr_data  (wr_data),
        .half_div (half_div),
        .mdc      (mdc),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .mdio_in  (mdio_in),
        .busy     (busy),
        .done     (done),
        .rd_data  (rd_data),
        .err      (err)
    );

    // Bus monitor and PHY responder, sampled away from the active edge.
    always @(negedge clk) begin
        clk_n = clk_n + 1;
        if (busy && !prev_busy) begin
            rise_k = 0;
            drv_v = '0;
            oe_v = '0;
            spacing_bad = 0;
            hi_change_bad = 0;
        end
        if (mdc && !prev_mdc) begin
            if (rise_k < 80) begin
                drv_v[79-rise_k] = mdio_out;
                oe_v[79-rise_k] = mdio_oe;
            end
            if (rise_k > 0 && (clk_n - last_rise) != 2 * exp_h) spacing_bad = spacing_bad + 1;
            last_rise = clk_n;
            if (rise_k == 46) mdio_in = phy_present ? 1'b0 : 1'b1;
            else if (rise_k >= 47 && rise_k <= 62 && phy_present) mdio_in = phy_word[62-rise_k];
            else mdio_in = 1'b1;
            rise_k = rise_k + 1;
        end
        if (mdc && prev_mdc && (mdio_out != prev_out || mdio_oe != prev_oe))
            hi_change_bad = hi_change_bad + 1;
        prev_mdc = mdc;
        prev_out = mdio_out;
        prev_oe = mdio_oe;
        prev_busy = busy;
    end

    task automatic chk(input string req, input string what, input logic [79:0] act, input logic [79:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Run one frame; optionally strobe a conflicting start mid-frame.
    task automatic run_frame(input logic rd, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] wd, input logic [7:0] h, input logic present,
                             input logic [15:0] pw, input logic intrude,
                             output int cyc, output int done_cnt);
        int guard;
        @(negedge clk);
        rd_req = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; half_div = h;
        exp_h = (h == 0) ? 1 : int'(h);
        phy_present = present; phy_word = pw;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cyc = 0; done_cnt = 0; guard = 0;
        while (!done && guard < 5000) begin
            if (busy) cyc = cyc + 1;
            if (intrude && cyc == 100) begin
                start = 1'b1; rd_req = ~rd; phy_addr = ~pa; wr_data = ~wd;
            end else begin
                start = 1'b0;
            end
            guard = guard + 1;
            @(negedge clk);
        end
        start = 1'b0;
        if (done) done_cnt = done_cnt + 1;
        @(negedge clk);
        if (done) done_cnt = done_cnt + 1;
    endtask

    task automatic t_reset;
        chk("R11", "reset mdc", {79'd0, mdc}, 80'd0);
        chk("R11", "reset oe", {79'd0, mdio_oe}, 80'd0);
        chk("R11", "reset busy/done/err", {77'd0, busy, done, err}, 80'd0);
        chk("R11", "reset rd_data", {64'd0, rd_data}, 80'd0);
    endtask

    task automatic t_write(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] wd, input logic [7:0] h);
        int cyc, dc, hh;
        hh = (h == 0) ? 1 : int'(h);
        run_frame(1'b0, pa, ra, wd, h, 1'b1, 16'h0, 1'b0, cyc, dc);
        chk("R9", "write frame cycles", 80'(rise_k), 80'd65);
        chk("R10", "write busy length", 80'(cyc), 80'(65 * 2 * hh));
        chk("R1", "preamble bits", {48'd0, drv_v[79:48]}, {48'd0, 32'hFFFF_FFFF});
        chk("R2", "write start/opcode", {76'd0, drv_v[47:44]}, {76'd0, 4'b0101});
        chk("R3", "write addresses", {70'd0, drv_v[43:34]}, {70'd0, pa, ra});
        chk("R9", "write ta+data", {62'd0, drv_v[33:16]}, {62'd0, 2'b10, wd});
        chk("R9", "write oe pattern", {15'd0, oe_v[79:15]}, {15'd0, {64{1'b1}}, 1'b0});
        chk("R4", "phase spacing / hold", 80'(spacing_bad + hi_change_bad), 80'd0);
        chk("R12", "write done pulse", 80'(dc), 80'd1);
    endtask

    task automatic t_read(input logic [4:0] pa, input logic [4:0] ra, input logic [15:0] pw, input logic [7:0] h);
        int cyc, dc, hh;
        hh = (h == 0) ? 1 : int'(h);
        run_frame(1'b1, pa, ra, 16'h0, h, 1'b1, pw, 1'b0, cyc, dc);
        chk("R8", "read frame cycles", 80'(rise_k), 80'd64);
        chk("R10", "read busy length", 80'(cyc), 80'(64 * 2 * hh));
        chk("R2", "read start/opcode", {76'd0, drv_v[47:44]}, {76'd0, 4'b0110});
        chk("R3", "read addresses", {70'd0, drv_v[43:34]}, {70'd0, pa, ra});
        chk("R5", "read oe pattern", {16'd0, oe_v[79:16]}, {16'd0, {46{1'b1}}, 18'd0});
        chk("R7", "read data", {64'd0, rd_data}, {64'd0, pw});
        chk("R6", "read err clear", {79'd0, err}, 80'd0);
        chk("R4", "phase spacing / hold", 80'(spacing_bad + hi_change_bad), 80'd0);
        chk("R12", "read done pulse", 80'(dc), 80'd1);
    endtask

    task automatic t_absent(input logic [7:0] h);
        int cyc, dc;
        run_frame(1'b1, 5'h07, 5'h02, 16'h0, h, 1'b0, 16'hFFFF, 1'b0, cyc, dc);
        chk("R6", "absent frame cycles", 80'(rise_k), 80'd79);
        chk("R6", "absent busy length", 80'(cyc), 80'(79 * 2 * int'(h)));
        chk("R6", "absent err", {79'd0, err}, 80'd1);
        chk("R6", "absent rd_data", {64'd0, rd_data}, 80'd0);
        chk("R6", "recovery released", {47'd0, oe_v[33:1]}, 80'd0);
    endtask

    task automatic t_intrude;
        int cyc, dc, k;
        run_frame(1'b0, 5'h0A, 5'h15, 16'h3C5A, 8'd1, 1'b1, 16'h0, 1'b1, cyc, dc);
        chk("R12", "frame unchanged by mid-frame start",
            {14'd0, drv_v[79:14]}, {14'd0, 32'hFFFF_FFFF, 4'b0101, 5'h0A, 5'h15, 2'b10, 16'h3C5A, 2'b00});
        chk("R12", "length unchanged", 80'(cyc), 80'(65 * 2));
        k = 0;
        for (int i = 0; i < 20; i++) begin
            if (busy) k = k + 1;
            @(negedge clk);
        end
        chk("R12", "no frame from ignored start", 80'(k), 80'd0);
    endtask

    task automatic t_hold;
        logic [15:0] d0;
        logic e0;
        int moved;
        d0 = rd_data; e0 = err; moved = 0;
        for (int i = 0; i < 30; i++) begin
            phy_addr = 5'(i); wr_data = 16'(i * 777); rd_req = i[0];
            @(negedge clk);
            if (mdc || mdio_oe) moved = moved + 1;
        end
        chk("R12", "rd_data held", {64'd0, rd_data}, {64'd0, d0});
        chk("R12", "err held", {79'd0, err}, {79'd0, e0});
        chk("R11", "idle mdc/oe low", 80'(moved), 80'd0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        bad = bad + 1;
        total = total + 1;
        $display("FAIL watchdog (R12 frame completion): actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write(5'h11, 5'h04, 16'hBEEF, 8'd2);
        t_write(5'h1F, 5'h00, 16'h8001, 8'd3);
        t_read(5'h01, 5'h1E, 16'hA5C3, 8'd1);
        t_hold();
        t_read(5'h10, 5'h01, 16'h0F0F, 8'd0);
        t_absent(8'd2);
        t_hold();
        t_read(5'h03, 5'h0C, 16'hFFFE, 8'd1);
        t_intrude();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule